// File: doc/BRIEF.md
# Configurable Interrupt Controller

This block gathers a vector of interrupt request lines from device pins and on-chip peripherals and turns them into two requests toward a processor core: a critical one and a non-critical one. Each line passes through a two-flop synchronizer. Its active level can be inverted, and it is then sensed either as a level or as an edge. The result is held in a status bit that is visible to software. An enable bit per source gates the source toward the outputs, and a class bit per source picks which of the two outputs it drives.

Software sets up the block through a single-port register interface. Writes are synchronous and reads are combinational. A vector register returns a base value plus a fixed stride times the index of the winning critical source. The core can use this value to jump directly to the right handler. The winner is the enabled, pending, critical source with the largest priority field. When two sources share the largest field, the lower index wins.

Each source has its own small state machine. It has two states, `CELL_IDLE` (not pending) and `CELL_PEND` (pending), and four transitions:
- **arm**: `CELL_IDLE`→`CELL_PEND`. In edge mode this happens on an inactive-to-active transition of the conditioned line. In level mode it happens while the line is active.
- **ack**: `CELL_PEND`→`CELL_IDLE`. In edge mode, software writes a 1 to the status bit and no new edge arrives in the same cycle.
- **drop**: `CELL_PEND`→`CELL_IDLE`. In level mode, the conditioned line becomes inactive.
- **hold**: stay in the current state in every other case.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every configuration register reads 0: all sources masked, level-sensed, active-high and non-critical, all priority fields 0, and the vector base 0. Both interrupt outputs are low.
- R2: A change on `irq_in` that is sampled at clock edge k appears in the STATUS register (address 0) after clock edge k+2.
- R3: When a source's POLARITY bit (address 3) is 1, the source is active while its line is low. When the bit is 0, the source is active while its line is high.
- R4: When a source's MODE bit (address 2) is 1, its status bit is set by an inactive-to-active transition and stays set after the line returns to inactive. Writing 1 to the bit in STATUS clears it, and writing 0 has no effect. If a new transition and a clear happen in the same cycle, the bit stays set.
- R5: When a source's MODE bit is 0, its status bit follows the conditioned line, and writes to STATUS do not change it.
- R6: A source whose ENABLE bit (address 1) is 0 still records its status, but it drives neither output and never wins the vector.
- R7: `crit_irq` is the registered OR of the sources that are pending, enabled and have CLASS bit (address 4) set to 1. `ncrit_irq` is the same for CLASS bit 0. Each output follows its sources one cycle after the status bits.
- R8: VECTOR (address 6, read-only) reads VBASE (address 5) plus VEC_STRIDE (16) times the index of the winning critical source. It reads VBASE alone when no enabled critical source is pending.
- R9: Among the enabled, pending, critical sources, the one with the largest priority field (address 16+i, PRIO_W bits) wins, and a tie goes to the lower index.
- R10: ENABLE, MODE, POLARITY, CLASS, VBASE and the priority registers read back what was written, truncated to their width, with the upper bits 0. A write to VECTOR changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_SRC | Raw interrupt request lines, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| crit_irq | output | 1 | Critical interrupt request to the core |
| ncrit_irq | output | 1 | Non-critical interrupt request to the core |

## Verification
Some rules are checked by assertions on every cycle. A pending edge-mode bit stays set until it is acknowledged. An edge-mode bit only arms on a real inactive-to-active transition. A level-mode bit ignores clears while its line is active. Neither output rises without at least one enabled source of its class. The picked winner is always a candidate and is never beaten by a lower-index source with an equal or larger priority. VECTOR equals the base when there are no candidates.

Other properties need the bench's scenarios, which compare against a behavioural model on every clock. These are the exact synchronizer latency, polarity inversion, set-wins-over-clear, tie-breaking between equal priorities, the vector arithmetic, and read-back truncation.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Word addresses of the register map
    localparam int unsigned RA_STATUS  = 0;
    localparam int unsigned RA_ENABLE  = 1;
    localparam int unsigned RA_MODE    = 2;
    localparam int unsigned RA_POL     = 3;
    localparam int unsigned RA_CLASS   = 4;
    localparam int unsigned RA_VBASE   = 5;
    localparam int unsigned RA_VECTOR  = 6;
    localparam int unsigned RA_PRIO0   = 16;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_PEND = 1'b1
    } cell_state_e;

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol_lo,
    input  logic mode_edge,
    input  logic clr,
    output logic pend_o
);

    logic        cond;
    logic        prev_q;
    logic        rise;
    cell_state_e state_q;
    cell_state_e state_d;

    assign cond = sync_in ^ pol_lo;
    assign rise = cond & ~prev_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= cond;
        end
    end

    // Next state: arm, ack, drop, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: begin
                if (mode_edge ? rise : cond) state_d = CELL_PEND;
            end
            CELL_PEND: begin
                if (mode_edge) begin
                    if (clr && !rise) state_d = CELL_IDLE;
                end else if (!cond) begin
                    state_d = CELL_IDLE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == CELL_PEND);
    end

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_edge) && $past(pend_o) && !$past(clr)) |-> pend_o); // R4

    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pend_o) && $past(mode_edge)) |-> $past(cond && !prev_q)); // R4

    AST_LEVEL_IGNORES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mode_edge) && $past(cond)) |-> pend_o); // R5

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         cand_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 valid_o,
    output logic [IW-1:0]        idx_o
);

    logic [PW-1:0] best_prio;

    always_comb begin
        valid_o   = 1'b0;
        idx_o     = '0;
        best_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (!valid_o || prio_i[i] > best_prio)) begin
                valid_o   = 1'b1;
                idx_o     = IW'(i);
                best_prio = prio_i[i];
            end
        end
    end

    always_comb begin
        if (valid_o) begin
            AST_PICK_IN_CAND: assert (cand_i[idx_o]); // R9
            for (int j = 0; j < N; j++) begin
                if (IW'(j) < idx_o) begin
                    AST_PICK_TIE_LOW: assert (!(cand_i[j] && prio_i[j] >= prio_i[idx_o])); // R9
                end
            end
        end else begin
            AST_PICK_NONE: assert (cand_i == '0); // R8
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 8,
    parameter int unsigned PRIO_W     = 3,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned VEC_STRIDE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               crit_irq,
    output logic               ncrit_irq
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0]             en_q, mode_q, pol_q, cls_q;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0]              vbase_q;
    logic [NUM_SRC-1:0]             sync_v, pend_v, clr_v;
    logic [NUM_SRC-1:0]             crit_cand, ncrit_cand;
    logic                           win_valid;
    logic [IDX_W-1:0]               win_idx;
    logic [DATA_W-1:0]              vector;
    logic                           crit_q, ncrit_q;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            mode_q  <= '0;
            pol_q   <= '0;
            cls_q   <= '0;
            vbase_q <= '0;
            prio_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(RA_ENABLE): en_q    <= reg_wdata[NUM_SRC-1:0];
                ADDR_W'(RA_MODE):   mode_q  <= reg_wdata[NUM_SRC-1:0];
                ADDR_W'(RA_POL):    pol_q   <= reg_wdata[NUM_SRC-1:0];
                ADDR_W'(RA_CLASS):  cls_q   <= reg_wdata[NUM_SRC-1:0];
                ADDR_W'(RA_VBASE):  vbase_q <= reg_wdata;
                default: ;
            endcase
            for (int i = 0; i < NUM_SRC; i++) begin
                if (reg_addr == ADDR_W'(RA_PRIO0 + i)) prio_q[i] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    assign clr_v = (reg_wr && reg_addr == ADDR_W'(RA_STATUS)) ? reg_wdata[NUM_SRC-1:0] : '0;

    irq_sync2 #(.W(NUM_SRC)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (sync_v)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        irq_src_cell cell_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (sync_v[g]),
            .pol_lo    (pol_q[g]),
            .mode_edge (mode_q[g]),
            .clr       (clr_v[g]),
            .pend_o    (pend_v[g])
        );
    end

    assign crit_cand  = pend_v & en_q & cls_q;
    assign ncrit_cand = pend_v & en_q & ~cls_q;

    irq_prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) pick_i (
        .cand_i  (crit_cand),
        .prio_i  (prio_q),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    assign vector = win_valid ? (vbase_q + DATA_W'(win_idx) * DATA_W'(VEC_STRIDE)) : vbase_q;

    // Registered requests to the core
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crit_q  <= 1'b0;
            ncrit_q <= 1'b0;
        end else begin
            crit_q  <= |crit_cand;
            ncrit_q <= |ncrit_cand;
        end
    end

    assign crit_irq  = crit_q;
    assign ncrit_irq = ncrit_q;

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(RA_STATUS): reg_rdata[NUM_SRC-1:0] = pend_v;
            ADDR_W'(RA_ENABLE): reg_rdata[NUM_SRC-1:0] = en_q;
            ADDR_W'(RA_MODE):   reg_rdata[NUM_SRC-1:0] = mode_q;
            ADDR_W'(RA_POL):    reg_rdata[NUM_SRC-1:0] = pol_q;
            ADDR_W'(RA_CLASS):  reg_rdata[NUM_SRC-1:0] = cls_q;
            ADDR_W'(RA_VBASE):  reg_rdata = vbase_q;
            ADDR_W'(RA_VECTOR): reg_rdata = vector;
            default: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (reg_addr == ADDR_W'(RA_PRIO0 + i)) reg_rdata[PRIO_W-1:0] = prio_q[i];
                end
            end
        endcase
    end

    AST_CRIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        crit_irq |-> $past(|(en_q & cls_q))); // R6

    AST_NCRIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ncrit_irq |-> $past(|(en_q & ~cls_q))); // R7

    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_cand == '0) |-> (vector == vbase_q)); // R8

    AST_VEC_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (vector - vbase_q) % DATA_W'(VEC_STRIDE) == '0); // R8

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        crit_irq, ncrit_irq;

    int vectors = 0;
    int fails = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .crit_irq  (crit_irq),
        .ncrit_irq (ncrit_irq)
    );

    // Behavioural reference model
    bit [7:0]  m_stat, m_prev, m_s1, m_s2, m_en, m_mode, m_pol, m_cls;
    int        m_prio [8];
    bit [31:0] m_vbase;
    bit        m_crit, m_ncrit;

    function automatic bit [31:0] m_vector();
        int best = -1;
        for (int i = 0; i < 8; i++) begin
            if (m_stat[i] && m_en[i] && m_cls[i]) begin
                if (best < 0 || m_prio[i] > m_prio[best]) best = i;
            end
        end
        return (best < 0) ? m_vbase : m_vbase + 32'(best) * 32'd16;
    endfunction

    function automatic bit [31:0] m_read(input bit [4:0] a);
        if (a == 0) return {24'd0, m_stat};
        if (a == 1) return {24'd0, m_en};
        if (a == 2) return {24'd0, m_mode};
        if (a == 3) return {24'd0, m_pol};
        if (a == 4) return {24'd0, m_cls};
        if (a == 5) return m_vbase;
        if (a == 6) return m_vector();
        if (a >= 16 && a < 24) return 32'(m_prio[a - 16]);
        return 32'd0;
    endfunction

    function automatic string tag_of(input bit [4:0] a);
        if (a == 0) return "R2";
        if (a == 6) return "R8";
        return "R10";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0; m_prev = '0; m_s1 = '0; m_s2 = '0;
            m_en = '0; m_mode = '0; m_pol = '0; m_cls = '0;
            m_vbase = '0; m_crit = 0; m_ncrit = 0;
            for (int i = 0; i < 8; i++) m_prio[i] = 0;
        end else begin
            bit [7:0] clr, nstat, cond;
            clr = (reg_wr && reg_addr == 5'd0) ? reg_wdata[7:0] : 8'd0;
            m_crit  = |(m_stat & m_en & m_cls);
            m_ncrit = |(m_stat & m_en & ~m_cls);
            for (int i = 0; i < 8; i++) begin
                cond[i] = m_s2[i] ^ m_pol[i];
                if (m_mode[i]) nstat[i] = (cond[i] && !m_prev[i]) ? 1'b1 : (clr[i] ? 1'b0 : m_stat[i]);
                else           nstat[i] = cond[i];
            end
            m_stat = nstat;
            m_prev = cond;
            m_s2 = m_s1;
            m_s1 = irq_in;
            if (reg_wr) begin
                case (reg_addr)
                    5'd1: m_en = reg_wdata[7:0];
                    5'd2: m_mode = reg_wdata[7:0];
                    5'd3: m_pol = reg_wdata[7:0];
                    5'd4: m_cls = reg_wdata[7:0];
                    5'd5: m_vbase = reg_wdata;
                    default: if (reg_addr >= 16 && reg_addr < 24) m_prio[reg_addr - 16] = int'(reg_wdata[2:0]);
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7 crit_irq", {31'd0, crit_irq}, {31'd0, m_crit});
            chk("R7 ncrit_irq", {31'd0, ncrit_irq}, {31'd0, m_ncrit});
            chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(3);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1: reset state
        for (int a = 0; a < 24; a++) begin
            if (a < 7 || a >= 16) begin
                rd(5'(a), d);
                chk("R1 reset register", d, 32'd0);
            end
        end
        chk("R1 crit_irq reset", {31'd0, crit_irq}, 32'd0);
        chk("R1 ncrit_irq reset", {31'd0, ncrit_irq}, 32'd0);

        // R2: synchronizer latency
        @(posedge clk); #1;
        reg_addr = 5'd0; irq_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 status before latency", reg_rdata, 32'd0);
        @(negedge clk);
        chk("R2 status after latency", reg_rdata, 32'd1);

        // R6 / R7: masking and routing
        idle(3);
        chk("R6 masked source silent", {30'd0, crit_irq, ncrit_irq}, 32'd0);
        wr(5'd1, 32'h01);
        idle(3);
        chk("R7 non-critical route", {30'd0, crit_irq, ncrit_irq}, 32'd1);
        wr(5'd4, 32'h01);
        idle(3);
        chk("R7 critical route", {30'd0, crit_irq, ncrit_irq}, 32'd2);

        // R5: level status ignores write-one-to-clear
        wr(5'd0, 32'h01);
        rd(5'd0, d);
        chk("R5 level clear ignored", d, 32'h01);

        // R3: polarity inversion
        wr(5'd3, 32'h01);
        idle(2);
        rd(5'd0, d);
        chk("R3 inverted high line inactive", d, 32'h00);
        @(posedge clk); #1 irq_in[0] = 1'b0;
        idle(5);
        rd(5'd0, d);
        chk("R3 inverted low line active", d, 32'h01);
        wr(5'd3, 32'h00);
        wr(5'd1, 32'h00);
        wr(5'd4, 32'h00);
        idle(3);

        // R4: edge mode
        wr(5'd2, 32'h02);
        @(posedge clk); #1 irq_in[1] = 1'b1;
        @(posedge clk); #1 irq_in[1] = 1'b0;
        idle(6);
        rd(5'd0, d);
        chk("R4 pulse captured", d, 32'h02);
        wr(5'd0, 32'h00);
        rd(5'd0, d);
        chk("R4 write zero no effect", d, 32'h02);
        wr(5'd0, 32'h02);
        rd(5'd0, d);
        chk("R4 write one clears", d, 32'h00);
        @(posedge clk); #1 irq_in[1] = 1'b1;
        idle(6);
        wr(5'd0, 32'h02);
        idle(4);
        rd(5'd0, d);
        chk("R4 held line does not re-arm", d, 32'h00);
        @(posedge clk); #1 irq_in[1] = 1'b0;
        wr(5'd2, 32'h00);
        idle(4);

        // R8 / R9: priority and vector
        wr(5'd5, 32'h1000);
        wr(5'd18, 32'd1);
        wr(5'd19, 32'd5);
        wr(5'd21, 32'd5);
        wr(5'd4, 32'h2C);
        wr(5'd1, 32'h2C);
        @(posedge clk); #1 irq_in = 8'h2C;
        idle(6);
        rd(5'd6, d);
        chk("R9 tie goes to lower index", d, 32'h1030);
        wr(5'd21, 32'd6);
        rd(5'd6, d);
        chk("R8 higher priority vector", d, 32'h1050);
        wr(5'd1, 32'h0C);
        rd(5'd6, d);
        chk("R6 masked source loses vector", d, 32'h1030);
        @(posedge clk); #1 irq_in = 8'h00;
        idle(6);
        rd(5'd6, d);
        chk("R8 idle vector is base", d, 32'h1000);
        chk("R7 crit idle", {31'd0, crit_irq}, 32'd0);

        // R10: read-back width and read-only vector
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd1, d);
        chk("R10 enable truncated", d, 32'hFF);
        wr(5'd16, 32'hFFFF_FFFF);
        rd(5'd16, d);
        chk("R10 priority truncated", d, 32'h7);
        wr(5'd6, 32'hDEAD);
        rd(5'd5, d);
        chk("R10 vector write ignored", d, 32'h1000);
        idle(4);

        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule